// File: doc/BRIEF.md
# GPIO Interrupt Router

This block sits between three GPIO controllers and a platform interrupt controller. The three controllers have 14, 24 and 32 interrupt lines, 70 in all. The platform controller has only 41 inputs to give them. The router fills those inputs with 38 dedicated outputs and 3 shared outputs. Each GPIO controller owns exactly one shared output.

A 32-bit routing word is written by software. Each bit settles a contest between two fixed lines over one dedicated output:

- Bits 0 to 13 pair line i of controller 2 with line i of controller 0.
- Bits 14 to 31 pair line i of controller 2 with line i-14 of controller 1.
- Lines 18 to 23 of controller 1 have no rival and always own dedicated outputs 32 to 37.

The line that loses a contest is ORed into the shared output of its own controller. No line can be steered to any output other than its two fixed destinations. All routing is pure combinational logic on levels. Only the routing word is stored.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the routing word reads back as all zeros on `cfg_rd_data`.
- R2: A write (`cfg_wr_en` high at a rising edge) shows on `cfg_rd_data` and on the routing from that edge on. The word is unchanged in every cycle without a write, whatever `cfg_wr_data` holds.
- R3: For bit i in 0..13 with the bit at 0, `irq_direct[i]` follows `gpio_a[i]`, and `gpio_c[i]` contributes to `irq_shared_c`.
- R4: For bit i in 0..13 with the bit at 1, `irq_direct[i]` follows `gpio_c[i]`, and `gpio_a[i]` contributes to `irq_shared_a`.
- R5: For bit i in 14..31, `irq_direct[i]` follows `gpio_b[i-14]` when the bit is 0 and `gpio_c[i]` when the bit is 1. In the first case `gpio_c[i]` contributes to `irq_shared_c`; in the second `gpio_b[i-14]` contributes to `irq_shared_b`.
- R6: `irq_direct[32+k]` equals `gpio_b[18+k]` for k in 0..5 under any routing word, and those lines never affect `irq_shared_b`.
- R7: Each shared output is the OR of exactly those lines of its own controller that currently lose their contest. It is 0 when none of them is high, and a line that holds a dedicated output never raises it.
- R8: Outputs follow input line changes in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the routing word |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the routing word |
| cfg_wr_data | input | 32 | New routing word |
| cfg_rd_data | output | 32 | Current routing word |
| gpio_a | input | 14 | Interrupt lines of controller 0 |
| gpio_b | input | 24 | Interrupt lines of controller 1 |
| gpio_c | input | 32 | Interrupt lines of controller 2 |
| irq_direct | output | 38 | Dedicated outputs to the interrupt controller |
| irq_shared_a | output | 1 | Shared output of controller 0 |
| irq_shared_b | output | 1 | Shared output of controller 1 |
| irq_shared_c | output | 1 | Shared output of controller 2 |

## Verification
The bench builds the router with its default line counts of 14, 24 and 32. With those counts the test reaches three cases:

- both pairing regimes, below and above bit 14;
- the seam between them at bits 13 and 14;
- the six unpaired lines of controller 1.

Walking single lines under all-zero and all-one routing words shows that each line reaches exactly one destination. Mixed random words with random line levels exercise the shared ORs with several contributors at once.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;
  // default line counts of the three source controllers
  localparam int unsigned GR_LINES_A = 14;
  localparam int unsigned GR_LINES_B = 24;
  localparam int unsigned GR_LINES_C = 32;
endpackage

// File: rtl/route_ctrl_reg.sv
module route_ctrl_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl
);
  logic live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (wr_en) ctrl <= wr_data;
    end
  end

  // R2: a write lands at its edge, otherwise the word holds
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(wr_en)) |-> (ctrl == $past(wr_data)));
  a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(wr_en)) |-> $stable(ctrl));
endmodule

// File: rtl/route_pair_sel.sv
module route_pair_sel #(
  parameter int unsigned NA = 14,
  parameter int unsigned NB = 24,
  parameter int unsigned NC = 32,
  localparam int unsigned SOLO = NA + NB - NC,
  localparam int unsigned ND   = NC + SOLO
) (
  input  logic [NC-1:0] ctrl,
  input  logic [NA-1:0] ga,
  input  logic [NB-1:0] gb,
  input  logic [NC-1:0] gc,
  output logic [ND-1:0] direct,
  output logic [NA-1:0] fold_a,
  output logic [NB-1:0] fold_b,
  output logic [NC-1:0] fold_c
);
  for (genvar i = 0; i < NC; i++) begin : g_pair
    if (i < NA) begin : g_with_a
      assign direct[i] = ctrl[i] ? gc[i] : ga[i];
      assign fold_a[i] = ctrl[i] & ga[i];
    end else begin : g_with_b
      assign direct[i]    = ctrl[i] ? gc[i] : gb[i-NA];
      assign fold_b[i-NA] = ctrl[i] & gb[i-NA];
    end
    assign fold_c[i] = ~ctrl[i] & gc[i];
  end

  for (genvar k = 0; k < SOLO; k++) begin : g_solo
    assign direct[NC+k]      = gb[NC-NA+k];
    assign fold_b[NC-NA+k]   = 1'b0;
  end
endmodule

// File: rtl/route_or_merge.sv
module route_or_merge #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] fold,
  output logic         merged
);
  assign merged = |fold;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_route_pkg::*;
#(
  parameter int unsigned NA = GR_LINES_A,
  parameter int unsigned NB = GR_LINES_B,
  parameter int unsigned NC = GR_LINES_C,
  localparam int unsigned SOLO = NA + NB - NC,
  localparam int unsigned ND   = NC + SOLO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [NC-1:0] cfg_wr_data,
  output logic [NC-1:0] cfg_rd_data,
  input  logic [NA-1:0] gpio_a,
  input  logic [NB-1:0] gpio_b,
  input  logic [NC-1:0] gpio_c,
  output logic [ND-1:0] irq_direct,
  output logic          irq_shared_a,
  output logic          irq_shared_b,
  output logic          irq_shared_c
);
  logic [NC-1:0] ctrl;
  logic [NA-1:0] fold_a;
  logic [NB-1:0] fold_b;
  logic [NC-1:0] fold_c;

  route_ctrl_reg #(.W(NC)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
    .wr_data(cfg_wr_data), .ctrl(ctrl)
  );

  assign cfg_rd_data = ctrl;

  route_pair_sel #(.NA(NA), .NB(NB), .NC(NC)) u_sel (
    .ctrl(ctrl), .ga(gpio_a), .gb(gpio_b), .gc(gpio_c),
    .direct(irq_direct), .fold_a(fold_a), .fold_b(fold_b), .fold_c(fold_c)
  );

  route_or_merge #(.W(NA)) u_mrg_a (.fold(fold_a), .merged(irq_shared_a));
  route_or_merge #(.W(NB)) u_mrg_b (.fold(fold_b), .merged(irq_shared_b));
  route_or_merge #(.W(NC)) u_mrg_c (.fold(fold_c), .merged(irq_shared_c));

  // R7: controller 2 shared line tracks its unrouted lines
  a_r7_shared_c_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_c & ~cfg_rd_data) != '0) |-> irq_shared_c);
  a_r7_shared_c_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_c & ~cfg_rd_data) == '0) |-> !irq_shared_c);
  // R4: controller 0 shared line stays low when its losers are idle
  a_r4_shared_a_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_a & cfg_rd_data[NA-1:0]) == '0) |-> !irq_shared_a);
  // R5: controller 1 shared line raised by a losing paired line
  a_r5_shared_b_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_b[NC-NA-1:0] & cfg_rd_data[NC-1:NA]) != '0) |-> irq_shared_b);
  // R6: unpaired lines pass straight through
  a_r6_solo_pass: assert property (@(posedge clk) disable iff (!rst_n)
    irq_direct[ND-1:NC] == gpio_b[NB-1:NC-NA]);
endmodule

// File: tb/gpio_irq_router_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [13:0] gpio_a = '0;
  logic [23:0] gpio_b = '0;
  logic [31:0] gpio_c = '0;
  logic [37:0] irq_direct;
  logic        irq_shared_a, irq_shared_b, irq_shared_c;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] m_ctrl = '0;

  always #2.5 clk = ~clk;

  gpio_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .gpio_a(gpio_a), .gpio_b(gpio_b), .gpio_c(gpio_c),
    .irq_direct(irq_direct), .irq_shared_a(irq_shared_a),
    .irq_shared_b(irq_shared_b), .irq_shared_c(irq_shared_c)
  );

  // behavioural model of the routing word
  always @(posedge clk) begin
    if (!rst_n) m_ctrl <= '0;
    else if (cfg_wr_en) m_ctrl <= cfg_wr_data;
  end

  task automatic expect_all(input string req);
    logic [37:0] e_dir;
    logic e_a, e_b, e_c;
    e_dir = '0; e_a = 0; e_b = 0; e_c = 0;
    for (int i = 0; i < 32; i++) begin
      if (m_ctrl[i]) begin
        e_dir[i] = gpio_c[i];
        if (i < 14) e_a = e_a | gpio_a[i];
        else        e_b = e_b | gpio_b[i-14];
      end else begin
        e_dir[i] = (i < 14) ? gpio_a[i] : gpio_b[i-14];
        e_c = e_c | gpio_c[i];
      end
    end
    for (int k = 0; k < 6; k++) e_dir[32+k] = gpio_b[18+k];
    n_vec += 5;
    if (cfg_rd_data !== m_ctrl) begin
      n_bad++; $display("FAIL %s rd_data act=%h exp=%h", req, cfg_rd_data, m_ctrl);
    end
    if (irq_direct !== e_dir) begin
      n_bad++; $display("FAIL %s direct act=%h exp=%h", req, irq_direct, e_dir);
    end
    if (irq_shared_a !== e_a) begin
      n_bad++; $display("FAIL %s shared_a act=%b exp=%b", req, irq_shared_a, e_a);
    end
    if (irq_shared_b !== e_b) begin
      n_bad++; $display("FAIL %s shared_b act=%b exp=%b", req, irq_shared_b, e_b);
    end
    if (irq_shared_c !== e_c) begin
      n_bad++; $display("FAIL %s shared_c act=%b exp=%b", req, irq_shared_c, e_c);
    end
  endtask

  task automatic step(input string req, input logic [13:0] a, input logic [23:0] b,
                      input logic [31:0] c, input logic we, input logic [31:0] wd);
    @(posedge clk); #1;
    gpio_a = a; gpio_b = b; gpio_c = c; cfg_wr_en = we; cfg_wr_data = wd;
    @(negedge clk);
    expect_all(req);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    expect_all("R1");                                  // R1 reset word zero
    // R3: word zero, walk controller 0 and controller 2 lines
    for (int i = 0; i < 14; i++) step("R3", 14'(1) << i, '0, '0, 0, '0);
    for (int i = 0; i < 32; i++) step("R3", '0, '0, 32'(1) << i, 0, '0);
    // R5: word zero, walk controller 1 lines (paired and unpaired, R6)
    for (int i = 0; i < 24; i++) step("R5", '0, 24'(1) << i, '0, 0, '0);
    // R2: write all ones, then junk data without strobe must not land
    step("R2", '0, '0, '0, 1, 32'hFFFF_FFFF);
    step("R2", '0, '0, '0, 0, 32'h1234_5678);
    step("R2", '0, '0, '0, 0, 32'h0);
    // R4: word all ones, walk controller 0 lines and controller 2 lines
    for (int i = 0; i < 14; i++) step("R4", 14'(1) << i, '0, '0, 0, '0);
    for (int i = 0; i < 32; i++) step("R4", '0, '0, 32'(1) << i, 0, '0);
    // R5/R6: word all ones, walk controller 1
    for (int i = 0; i < 24; i++) step("R6", '0, 24'(1) << i, '0, 0, '0);
    // R7: seam at bits 13/14, both sides lose
    step("R7", '0, '0, '0, 1, 32'h0000_2000);
    step("R7", 14'h2000, 24'h1, 32'h0000_6000, 0, '0);
    step("R7", 14'h3FFF, 24'hFFFFFF, 32'hFFFF_FFFF, 0, '0);
    // R8: random words and lines, inputs change every cycle
    for (int n = 0; n < 400; n++)
      step("R8", 14'($urandom), 24'($urandom), $urandom, ($urandom % 4) == 0, $urandom);
    // R1: reset clears the word again
    @(posedge clk); #1 rst_n = 1'b0; cfg_wr_en = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    expect_all("R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule